// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits the peak current in an H-bridge load. It does so with a fixed off-time. A digital comparator flag goes high when the sensed load current is above a programmed threshold. The chopper watches that flag only while the bridge is driving. When it sees the flag, it asks the bridge to brake for a fixed number of clock cycles, with both low-side switches on so the current decays slowly. When that time has passed, control goes back to the input decoder, and the bridge returns to whatever drive state its inputs command at that moment.

Turning the bridge on makes switching spikes on the comparator. Every time drive starts or resumes, a blanking window opens, and any flag seen inside it is discarded. The input decoder supplies two signals: a level that shows a drive state is commanded, and a one-cycle pulse when a drive state is entered. In coast, brake or sleep the chopper stays idle. The comparator flag arrives from the analog domain, so it is synchronized first. A saturating count of trip events is provided so that tests can observe it.

Top module: `current_chopper`

## Requirements
- R1: While reset is asserted, and asynchronously as soon as it is asserted, `brake_req_o` is 0 and `trip_count_o` is 0.
- R2: A drive is started at edge s, when `drive_start_i` and `drive_active_i` are both 1. `trip_flag_i` is first sampled high at edge s+d and stays high. `brake_req_o` is then 1 after edge max(s+d+SYNC_STAGES, s+BLANK_CYC+1).
- R3: Once raised, `brake_req_o` stays 1 for exactly OFF_CYC clock cycles. This holds no matter what `trip_flag_i` or the drive inputs do.
- R4: If `drive_active_i` is 0 when the off-time ends, the chopper goes idle. A later trip is then ignored until a new drive start arrives.
- R5: The comparator flag is ignored while it is seen within BLANK_CYC+1 edges of a drive start. A trip pulse that falls only inside that window never raises `brake_req_o`.
- R6: A drive start during blanking or during drive restarts the blanking window, counted from the new start.
- R7: While `drive_active_i` is 0, neither `trip_flag_i` nor `drive_start_i` raises `brake_req_o`, and `trip_count_o` does not change.
- R8: A drive start during the off-time is ignored. The off-time is not shortened or restarted.
- R9: `trip_count_o` goes up by one on the edge that raises `brake_req_o`, and at no other time. It stops at its all-ones value.
- R10: If the trip flag stays high and drive stays active, the chopper repeats its cycle with a period of OFF_CYC+BLANK_CYC+1 cycles: blanking restarts after each off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_flag_i | input | 1 | Comparator flag, high while the current is above the trip level (asynchronous) |
| drive_active_i | input | 1 | A forward or reverse drive state is commanded |
| drive_start_i | input | 1 | One-cycle pulse when a drive state is entered |
| brake_req_o | output | 1 | Request to force both low-side switches on |
| trip_count_o | output | TRIP_CNT_W | Saturating count of trip events |

## Verification
Some properties hold on every cycle, and the assertions check those:
- a brake request rises only after a synchronized trip, and only while drive is active;
- no brake request rises sooner than BLANK_CYC+1 edges after a drive start;
- every brake pulse is exactly OFF_CYC long;
- the trip count moves only with a rising brake request, and it saturates.

Other behaviour depends on how the stimulus is timed, and only the bench scenarios can show it:
- which edge detects a trip pulse that overlaps the end of the blanking window;
- how blanking restarts after a new drive start;
- that the block goes idle when drive is inactive at the end of an off-time;
- the period of repeated chopping under a stuck flag.

// File: rtl/chop_pkg.sv
package chop_pkg;
  // Control phases of the chopper
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,  // no drive commanded, flag not watched
    CH_BLANK = 2'd1,  // drive just started, flag masked
    CH_DRIVE = 2'd2,  // drive running, flag watched
    CH_OFF   = 2'd3   // forced slow decay
  } chop_state_e;
endpackage

// File: rtl/chop_flag_sync.sv
// Multi-stage synchronizer, cleared asynchronously.
module chop_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/chop_interval_timer.sv
// Down-counter shared by the blanking and off-time intervals.
module chop_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_en | dec_en;
    if (load_en) cnt_d = load_val;
    else         cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/chop_event_counter.sv
// Saturating event counter.
module chop_event_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = inc_en && (count_q != '1);
    count_d  = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/chop_sequencer.sv
// Phase controller: blanking, watching, forced decay.
module chop_sequencer
  import chop_pkg::*;
#(
  parameter int OFF_CYC   = 3125,
  parameter int BLANK_CYC = 250,
  parameter int CNT_W     = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_active,
  input  logic             drive_start,
  input  logic             trip_seen,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_dec,
  output logic             trip_evt,
  output logic             brake
);
  localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] OFF_LD   = CNT_W'(OFF_CYC - 1);

  chop_state_e state_q;
  chop_state_e state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = BLANK_LD;
    tmr_dec  = 1'b0;
    trip_evt = 1'b0;
    case (state_q)
      CH_IDLE: begin
        if (drive_active && drive_start) begin
          state_d  = CH_BLANK;
          tmr_load = 1'b1;
        end
      end
      CH_BLANK: begin
        if (!drive_active) begin
          state_d = CH_IDLE;
        end else if (drive_start) begin
          tmr_load = 1'b1;              // restart the mask window
        end else if (tmr_zero) begin
          state_d = CH_DRIVE;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      CH_DRIVE: begin
        if (!drive_active) begin
          state_d = CH_IDLE;
        end else if (drive_start) begin
          state_d  = CH_BLANK;
          tmr_load = 1'b1;
        end else if (trip_seen) begin
          state_d  = CH_OFF;
          tmr_load = 1'b1;
          tmr_val  = OFF_LD;
          trip_evt = 1'b1;
        end
      end
      CH_OFF: begin
        if (tmr_zero) begin
          if (drive_active) begin
            state_d  = CH_BLANK;
            tmr_load = 1'b1;
          end else begin
            state_d = CH_IDLE;
          end
        end else begin
          tmr_dec = 1'b1;
        end
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_IDLE;
    else        state_q <= state_d;
  end

  assign brake = (state_q == CH_OFF);
endmodule

// File: rtl/current_chopper.sv
// Fixed off-time peak current chopper.
module current_chopper #(
  parameter int OFF_CYC     = 3125,
  parameter int BLANK_CYC   = 250,
  parameter int SYNC_STAGES = 2,
  parameter int TRIP_CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trip_flag_i,
  input  logic                  drive_active_i,
  input  logic                  drive_start_i,
  output logic                  brake_req_o,
  output logic [TRIP_CNT_W-1:0] trip_count_o
);
  localparam int MAX_CYC    = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC) + 1;
  localparam int RST_STAGES = 2;

  logic             rst_int_n;
  logic             trip_seen;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_dec;
  logic             tmr_zero;
  logic             trip_evt;

  // Reset: asserted at once, released on the clock
  chop_flag_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  chop_flag_sync #(.STAGES(SYNC_STAGES)) u_trip_sync (
    .clk(clk), .rst_n(rst_int_n), .d(trip_flag_i), .q(trip_seen)
  );

  chop_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .load_en(tmr_load), .load_val(tmr_val),
    .dec_en(tmr_dec), .zero(tmr_zero)
  );

  chop_sequencer #(
    .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .drive_active(drive_active_i), .drive_start(drive_start_i),
    .trip_seen(trip_seen), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_dec(tmr_dec),
    .trip_evt(trip_evt), .brake(brake_req_o)
  );

  chop_event_counter #(.CNT_W(TRIP_CNT_W)) u_trip_cnt (
    .clk(clk), .rst_n(rst_int_n), .inc_en(trip_evt), .count(trip_count_o)
  );
endmodule

// File: rtl/current_chopper_chk.sv
// Cycle-level properties of the chopper, attached by bind.
module current_chopper_chk #(
  parameter int OFF_CYC    = 3125,
  parameter int BLANK_CYC  = 250,
  parameter int TRIP_CNT_W = 8,
  parameter int CNT_W      = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  trip_seen,
  input logic                  drive_active_i,
  input logic                  drive_start_i,
  input logic                  brake_req_o,
  input logic [TRIP_CNT_W-1:0] trip_count_o
);
  localparam int RW = CNT_W + 1;

  logic [RW-1:0] run_q;    // consecutive brake cycles
  logic [RW-1:0] since_q;  // edges since the last drive start

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (brake_req_o) run_q <= run_q + RW'(1);
    else                  run_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              since_q <= '1;
    else if (drive_active_i && drive_start_i) since_q <= '0;
    else if (since_q != '1)                  since_q <= since_q + RW'(1);
  end

  AST_BRAKE_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brake_req_o) |-> $past(trip_seen)); // R2

  AST_OFF_TIME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brake_req_o) |-> (run_q == RW'(OFF_CYC))); // R3

  AST_OFF_TIME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    brake_req_o |-> (run_q < RW'(OFF_CYC))); // R3

  AST_BLANK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brake_req_o) |-> (since_q >= RW'(BLANK_CYC + 1))); // R5

  AST_IDLE_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brake_req_o) |-> $past(drive_active_i)); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trip_count_o) |->
      ($rose(brake_req_o) && (trip_count_o == $past(trip_count_o) + TRIP_CNT_W'(1)))); // R9

  AST_COUNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_count_o == '1) |=> (trip_count_o == '1)); // R9
endmodule

bind current_chopper current_chopper_chk #(
  .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC), .TRIP_CNT_W(TRIP_CNT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .trip_seen(trip_seen),
  .drive_active_i(drive_active_i), .drive_start_i(drive_start_i),
  .brake_req_o(brake_req_o), .trip_count_o(trip_count_o)
);

// File: tb/test_current_chopper.sv
`timescale 1ns/1ps
module test_current_chopper;
  localparam int OFFC  = 20;
  localparam int BLK   = 6;
  localparam int SYNC  = 2;
  localparam int CW    = 3;
  localparam int CMAX  = (1 << CW) - 1;
  localparam int NVEC  = 6;
  // {trip offset from start edge, trip length in cycles}
  localparam int VEC [NVEC][2] = '{'{10, 3}, '{1, 2}, '{3, 3}, '{2, 3}, '{0, 15}, '{30, 1}};

  logic          clk;
  logic          rst_n;
  logic          trip_flag_i;
  logic          drive_active_i;
  logic          drive_start_i;
  logic          brake_req_o;
  logic [CW-1:0] trip_count_o;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit done = 0;

  current_chopper #(
    .OFF_CYC(OFFC), .BLANK_CYC(BLK), .SYNC_STAGES(SYNC), .TRIP_CNT_W(CW)
  ) i_current_chopper (
    .clk(clk), .rst_n(rst_n), .trip_flag_i(trip_flag_i),
    .drive_active_i(drive_active_i), .drive_start_i(drive_start_i),
    .brake_req_o(brake_req_o), .trip_count_o(trip_count_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Edge (relative to the start edge) at which the brake rises, or -1 for none
  function automatic int exp_rise(input int d, input int len);
    int e;
    e = d + SYNC;
    if (e < BLK + 1) e = BLK + 1;
    if (e <= d + len - 1 + SYNC) return e;
    return -1;
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic run_case(input int d, input int len, input int st2, input int act_off,
                          input int win, output int rise1, output int rise2,
                          output int highs, output int nrise);
    bit prev;
    rise1 = -1; rise2 = -1; highs = 0; nrise = 0; prev = 1'b0;
    @(negedge clk);
    drive_active_i = 1'b1;
    drive_start_i  = 1'b1;
    trip_flag_i    = (0 >= d) && (0 < d + len);
    for (int n = 0; n < win; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (brake_req_o) begin
        highs++;
        if (!prev) begin
          nrise++;
          if (rise1 < 0) rise1 = n;
          else if (rise2 < 0) rise2 = n;
        end
      end
      prev = brake_req_o;
      drive_start_i  = (n + 1 == st2);
      drive_active_i = !(act_off >= 0 && n + 1 >= act_off);
      trip_flag_i    = (n + 1 >= d) && (n + 1 < d + len);
    end
    drive_active_i = 1'b0;
    drive_start_i  = 1'b0;
    trip_flag_i    = 1'b0;
    repeat (OFFC + BLK + 6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int r1, r2, hi, nr, er;
    int bad_hi;
    rst_n = 1'b0; trip_flag_i = 1'b0; drive_active_i = 1'b0; drive_start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(brake_req_o == 1'b0, "R1 brake in reset", int'(brake_req_o), 0);
    check(trip_count_o == '0, "R1 count in reset", int'(trip_count_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Vector table: trip pulses at various offsets from the drive start
    for (int i = 0; i < NVEC; i++) begin
      run_case(VEC[i][0], VEC[i][1], -1, -1, 70, r1, r2, hi, nr);
      er = exp_rise(VEC[i][0], VEC[i][1]);
      check(r1 == er, (er < 0) ? "R5 blanked trip" : "R2 trip detect edge", r1, er);
      check(hi == ((er < 0) ? 0 : OFFC), "R3 off-time length", hi, (er < 0) ? 0 : OFFC);
      if (er >= 0) exp_cnt = sat(exp_cnt + 1);
      check(int'(trip_count_o) == exp_cnt, "R9 trip count", int'(trip_count_o), exp_cnt);
    end

    // R6: second start inside blanking restarts the window
    run_case(8, 3, 4, -1, 70, r1, r2, hi, nr);
    er = 4 + exp_rise(4, 3);
    check(r1 == er, "R6 restart in blank", r1, er);
    exp_cnt = sat(exp_cnt + 1);

    // R6: start during drive reopens blanking and hides the trip
    run_case(22, 3, 20, -1, 70, r1, r2, hi, nr);
    check(r1 == -1, "R6 restart in drive", r1, -1);

    // R8: start pulse inside the off-time is ignored
    run_case(10, 3, 15, -1, 70, r1, r2, hi, nr);
    check(r1 == 12, "R8 rise edge", r1, 12);
    check(hi == OFFC, "R8 off-time unchanged", hi, OFFC);
    exp_cnt = sat(exp_cnt + 1);

    // R4: drive drops during off-time, flag held high: idle afterwards
    run_case(10, 60, -1, 15, 70, r1, r2, hi, nr);
    check(hi == OFFC && nr == 1, "R4 single off-time then idle", hi, OFFC);
    exp_cnt = sat(exp_cnt + 1);
    @(negedge clk);
    drive_active_i = 1'b1; trip_flag_i = 1'b1;
    bad_hi = 0;
    repeat (30) begin
      @(negedge clk);
      if (brake_req_o) bad_hi++;
    end
    check(bad_hi == 0, "R4 no trip without new start", bad_hi, 0);
    drive_active_i = 1'b0; trip_flag_i = 1'b0;

    // R7: inactive drive, flag and start pulses toggling
    bad_hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      trip_flag_i   = k[1];
      drive_start_i = (k % 5 == 0);
      if (brake_req_o) bad_hi++;
    end
    trip_flag_i = 1'b0; drive_start_i = 1'b0;
    repeat (4) @(negedge clk);
    check(bad_hi == 0, "R7 brake while inactive", bad_hi, 0);
    check(int'(trip_count_o) == exp_cnt, "R7 count unchanged", int'(trip_count_o), exp_cnt);

    // R10: stuck flag, repeating cycle; R9 saturation
    run_case(0, 1000, -1, -1, 70, r1, r2, hi, nr);
    check(r1 == BLK + 1, "R10 first rise", r1, BLK + 1);
    check(r2 == BLK + 1 + OFFC + BLK + 1, "R10 repeat period", r2, BLK + 1 + OFFC + BLK + 1);
    exp_cnt = sat(exp_cnt + nr);
    check(int'(trip_count_o) == CMAX && exp_cnt == CMAX, "R9 saturation",
          int'(trip_count_o), CMAX);

    // R1: reset during an off-time clears outputs at once
    @(negedge clk);
    drive_active_i = 1'b1; drive_start_i = 1'b1; trip_flag_i = 1'b1;
    @(negedge clk);
    drive_start_i = 1'b0;
    repeat (BLK + 4) @(negedge clk);
    check(brake_req_o == 1'b1, "R2 brake before reset", int'(brake_req_o), 1);
    rst_n = 1'b0;
    #1;
    check(brake_req_o == 1'b0, "R1 async clear brake", int'(brake_req_o), 0);
    check(trip_count_o == '0, "R1 async clear count", int'(trip_count_o), 0);
    drive_active_i = 1'b0; trip_flag_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule